// File: doc/BRIEF.md
# Receiver-Detect Link Controller

This block is the front end of a link-training state machine, covering only the part that looks for a far-end receiver. It sits between a multi-lane serial physical layer and a link controller. It holds the link in a quiet wait so that the transmit lines can discharge, then asks the physical layer for a receiver-detect operation. If at least one lane finds a receiver, it moves on to a minimal polling stage. Training-sequence exchange is reduced to a single completion input. When that input does not arrive within a bounded time, the block falls back to the quiet wait and flags the timeout for one cycle.

The physical layer can share its lanes with other protocols. A lane that is not assigned to this link always looks electrically idle to the state machine, whatever its raw status says. This stops a foreign protocol on a shared lane from cutting the quiet wait short. Each lane also has a two-bit override field. Setting it to the force code makes the detect report success, which is only allowed when the link uses exactly one lane. After a detect that finds nothing, the next attempt always waits out the full quiet time, so two detects never run back to back.

Top module: `lnk_detect_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it falls, `state_o` is 0 (quiet) and `det_req`, `det_lanes` and `poll_timeout` are all zero. The state codes are 0 = quiet, 1 = active, 2 = polling, 3 = linked.
- R2: When no lane leaves electrical idle, the controller stays in quiet for exactly `QUIET_CYCLES` cycles and then enters active. `det_req` is high for exactly the first active cycle.
- R3: In quiet, a lane that is assigned (`lane_assign[i]`=1) and reports non-idle (`lane_eidle[i]`=0) moves the controller to active on the next cycle, with `det_req` high. This applies unless the quiet period follows a failed detect.
- R4: A lane with `lane_assign[i]`=0 is treated as idle, so a 0 on its `lane_eidle` bit does not shorten the quiet wait. Such a lane is also never reported in `det_lanes`.
- R5: In active, an `rx_det_valid` pulse whose effective result has no bit set returns the controller to quiet with `det_lanes` zero. That quiet period lasts the full `QUIET_CYCLES` even if an assigned lane is non-idle.
- R6: In active, an `rx_det_valid` pulse with a non-empty effective result moves the controller to polling. `det_lanes` then equals `lane_assign & rx_det_result`, or that value plus the forced lane from R7.
- R7: When exactly one lane is assigned and that lane's override field `ovrd_ctrl[2i+1:2i]` equals 2, the lane's detect result counts as success. The field values 0, 1 and 3 have no effect.
- R8: When more than one lane is assigned, the override fields are ignored.
- R9: Without `ts_done`, polling lasts exactly `POLL_CYCLES` cycles and then returns to quiet. `poll_timeout` is high for exactly the first quiet cycle, and `det_lanes` is cleared.
- R10: `ts_done` during polling moves the controller to linked (3). It stays there until reset, with `poll_timeout` low.
- R11: The quiet timer starts from zero on every entry to quiet, so every full quiet period has the same length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_assign | input | NUM_LANES | 1 = lane belongs to this link |
| lane_eidle | input | NUM_LANES | Raw electrical-idle status, 1 = idle |
| ovrd_ctrl | input | 2*NUM_LANES | Per-lane detect override field, code 2 forces success |
| rx_det_valid | input | 1 | Detect operation finished this cycle |
| rx_det_result | input | NUM_LANES | Per-lane receiver found, valid with rx_det_valid |
| ts_done | input | 1 | Training sequences completed |
| det_req | output | 1 | One-cycle request to start a receiver detect |
| state_o | output | 2 | Current state code |
| det_lanes | output | NUM_LANES | Lanes on which a receiver was accepted |
| poll_timeout | output | 1 | One-cycle pulse when polling times out |

## Verification
The risky internal state is the retry flag and the two cycle counters. A lost retry flag or a counter that does not restart shows up at `state_o` as a quiet period shorter than `QUIET_CYCLES`. The bench catches this within one quiet period by measuring the number of cycles from the first quiet cycle to the first active cycle. A masking error on an unassigned lane, or an override that acts in a multi-lane setup, shows up either as an early `det_req` or as a wrong `det_lanes` value. Either one is visible one cycle after the stimulus.

// File: rtl/ldc_pkg.sv
package ldc_pkg;
    typedef enum logic [1:0] {
        ST_QUIET  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_POLL   = 2'd2,
        ST_LINKED = 2'd3
    } ldc_state_e;

    localparam int          OVRD_W     = 2;
    localparam logic [1:0]  OVRD_FORCE = 2'd2;
endpackage

// File: rtl/ldc_cycle_timer.sv
module ldc_cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int            CW   = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (!done) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R11
    restart_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/ldc_lane_mask.sv
module ldc_lane_mask
    import ldc_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_LANES-1:0]        lane_assign,
    input  logic [NUM_LANES-1:0]        lane_eidle,
    input  logic [NUM_LANES*OVRD_W-1:0] ovrd_ctrl,
    input  logic [NUM_LANES-1:0]        rx_det_result,
    output logic                        idle_exit,
    output logic [NUM_LANES-1:0]        det_eff
);
    localparam int NCW = $clog2(NUM_LANES + 1);

    logic [NUM_LANES-1:0] eidle_masked;
    logic [NUM_LANES-1:0] force_ok;
    logic [NCW-1:0]       n_assigned;
    logic                 single_lane;

    always_comb begin
        n_assigned = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            n_assigned = n_assigned + NCW'(lane_assign[i]);
        end
        single_lane = (n_assigned == NCW'(1));
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign eidle_masked[g] = lane_assign[g] ? lane_eidle[g] : 1'b1;
        assign force_ok[g]     = single_lane && lane_assign[g]
                                 && (ovrd_ctrl[g*OVRD_W +: OVRD_W] == OVRD_FORCE);
        assign det_eff[g]      = lane_assign[g] && (rx_det_result[g] || force_ok[g]);
    end

    assign idle_exit = ~&eidle_masked;

    // R4
    unassigned_never_detected_chk: assert property (@(posedge clk) disable iff (rst)
        (det_eff & ~lane_assign) == '0);

    // R8
    multi_lane_no_force_chk: assert property (@(posedge clk) disable iff (rst)
        (n_assigned > NCW'(1)) |-> ((det_eff & ~rx_det_result) == '0));
endmodule

// File: rtl/ldc_fsm.sv
module ldc_fsm
    import ldc_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 idle_exit,
    input  logic                 quiet_done,
    input  logic                 poll_done,
    input  logic                 rx_det_valid,
    input  logic [NUM_LANES-1:0] det_eff,
    input  logic                 ts_done,
    output logic                 quiet_run,
    output logic                 poll_run,
    output ldc_state_e           state,
    output logic                 det_req,
    output logic [NUM_LANES-1:0] det_lanes,
    output logic                 poll_timeout
);
    typedef struct packed {
        ldc_state_e           st;
        logic                 req;
        logic [NUM_LANES-1:0] lanes;
        logic                 tmo;
        logic                 retry;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.req   = 1'b0;
        r_d.tmo   = 1'b0;
        unique case (r_q.st)
            ST_QUIET: begin
                if (quiet_done || (idle_exit && !r_q.retry)) begin
                    r_d.st    = ST_ACTIVE;
                    r_d.req   = 1'b1;
                    r_d.retry = 1'b0;
                end
            end
            ST_ACTIVE: begin
                if (rx_det_valid) begin
                    if (|det_eff) begin
                        r_d.st    = ST_POLL;
                        r_d.lanes = det_eff;
                    end else begin
                        r_d.st    = ST_QUIET;
                        r_d.lanes = '0;
                        r_d.retry = 1'b1;
                    end
                end
            end
            ST_POLL: begin
                if (ts_done) begin
                    r_d.st = ST_LINKED;
                end else if (poll_done) begin
                    r_d.st    = ST_QUIET;
                    r_d.tmo   = 1'b1;
                    r_d.lanes = '0;
                end
            end
            default: begin
                r_d.st = ST_LINKED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st    <= ST_QUIET;
            r_q.req   <= 1'b0;
            r_q.lanes <= '0;
            r_q.tmo   <= 1'b0;
            r_q.retry <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign quiet_run    = (r_q.st == ST_QUIET);
    assign poll_run     = (r_q.st == ST_POLL);
    assign state        = r_q.st;
    assign det_req      = r_q.req;
    assign det_lanes    = r_q.lanes;
    assign poll_timeout = r_q.tmo;

    // R2
    req_on_entry_chk: assert property (@(posedge clk) disable iff (rst)
        r_q.req |-> (r_q.st == ST_ACTIVE) && ($past(r_q.st) == ST_QUIET));

    // R5
    retry_full_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_QUIET && r_q.retry && !quiet_done) |=> (r_q.st == ST_QUIET));

    // R9
    timeout_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        r_q.tmo |-> (r_q.st == ST_QUIET) && ($past(r_q.st) == ST_POLL) && (r_q.lanes == '0));

    // R6
    lanes_clear_before_poll_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_QUIET || r_q.st == ST_ACTIVE) |-> (r_q.lanes == '0));

    // R10
    linked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_LINKED) |=> (r_q.st == ST_LINKED) && !r_q.tmo);
endmodule

// File: rtl/lnk_detect_ctrl.sv
module lnk_detect_ctrl
    import ldc_pkg::*;
#(
    parameter int NUM_LANES    = 4,
    parameter int QUIET_CYCLES = 2400000,
    parameter int POLL_CYCLES  = 4800000
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_LANES-1:0]        lane_assign,
    input  logic [NUM_LANES-1:0]        lane_eidle,
    input  logic [NUM_LANES*OVRD_W-1:0] ovrd_ctrl,
    input  logic                        rx_det_valid,
    input  logic [NUM_LANES-1:0]        rx_det_result,
    input  logic                        ts_done,
    output logic                        det_req,
    output logic [1:0]                  state_o,
    output logic [NUM_LANES-1:0]        det_lanes,
    output logic                        poll_timeout
);
    logic                 idle_exit;
    logic [NUM_LANES-1:0] det_eff;
    logic                 quiet_run, poll_run;
    logic                 quiet_done, poll_done;
    ldc_state_e           st;

    ldc_lane_mask #(.NUM_LANES(NUM_LANES)) u_mask (
        .clk           (clk),
        .rst           (rst),
        .lane_assign   (lane_assign),
        .lane_eidle    (lane_eidle),
        .ovrd_ctrl     (ovrd_ctrl),
        .rx_det_result (rx_det_result),
        .idle_exit     (idle_exit),
        .det_eff       (det_eff)
    );

    ldc_cycle_timer #(.LIMIT(QUIET_CYCLES)) u_quiet_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (quiet_run),
        .done (quiet_done)
    );

    ldc_cycle_timer #(.LIMIT(POLL_CYCLES)) u_poll_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (poll_run),
        .done (poll_done)
    );

    ldc_fsm #(.NUM_LANES(NUM_LANES)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .idle_exit    (idle_exit),
        .quiet_done   (quiet_done),
        .poll_done    (poll_done),
        .rx_det_valid (rx_det_valid),
        .det_eff      (det_eff),
        .ts_done      (ts_done),
        .quiet_run    (quiet_run),
        .poll_run     (poll_run),
        .state        (st),
        .det_req      (det_req),
        .det_lanes    (det_lanes),
        .poll_timeout (poll_timeout)
    );

    assign state_o = st;
endmodule

// File: tb/lnk_detect_ctrl_tb.sv
`timescale 1ns/1ps
module lnk_detect_ctrl_tb;
    localparam int N  = 4;
    localparam int QC = 20;
    localparam int PC = 15;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] lane_assign, lane_eidle, rx_det_result, det_lanes;
    logic [2*N-1:0] ovrd_ctrl;
    logic         rx_det_valid, ts_done, det_req, poll_timeout;
    logic [1:0]   state_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    lnk_detect_ctrl #(.NUM_LANES(N), .QUIET_CYCLES(QC), .POLL_CYCLES(PC)) u_dut (
        .clk(clk), .rst(rst), .lane_assign(lane_assign), .lane_eidle(lane_eidle),
        .ovrd_ctrl(ovrd_ctrl), .rx_det_valid(rx_det_valid), .rx_det_result(rx_det_result),
        .ts_done(ts_done), .det_req(det_req), .state_o(state_o),
        .det_lanes(det_lanes), .poll_timeout(poll_timeout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_state(input logic [1:0] tgt, input int maxc, output int n);
        n = 0;
        while (state_o != tgt && n < maxc) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_reset(input logic [N-1:0] asg);
        @(negedge clk);
        rst = 1'b1; lane_assign = asg; lane_eidle = '1; ovrd_ctrl = '0;
        rx_det_valid = 1'b0; rx_det_result = '0; ts_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic reach_active();
        int n;
        wait_state(2'd1, QC + 10, n);
    endtask

    task automatic detect(input logic [N-1:0] res);
        rx_det_valid = 1'b1; rx_det_result = res;
        @(negedge clk);
        rx_det_valid = 1'b0; rx_det_result = '0;
    endtask

    task automatic t_reset();
        do_reset(4'b0001);
        rst = 1'b1;
        @(negedge clk);
        chk(state_o == 2'd0 && !det_req && det_lanes == '0 && !poll_timeout,
            "R1 reset outputs", state_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(state_o == 2'd0 && !det_req && !poll_timeout, "R1 after release", state_o, 0);
    endtask

    task automatic t_full_wait();
        int n;
        do_reset(4'b0001);
        wait_state(2'd1, QC + 10, n);
        chk(n == QC, "R2 quiet length", n, QC);
        chk(det_req == 1'b1, "R2 det_req on entry", det_req, 1);
        @(negedge clk);
        chk(det_req == 1'b0 && state_o == 2'd1, "R2 det_req single cycle", det_req, 0);
    endtask

    task automatic t_early_exit();
        do_reset(4'b0011);
        repeat (3) @(negedge clk);
        chk(state_o == 2'd0, "R3 still quiet", state_o, 0);
        lane_eidle[1] = 1'b0;
        @(negedge clk);
        chk(state_o == 2'd1 && det_req, "R3 early exit", state_o, 1);
        lane_eidle = '1;
    endtask

    task automatic t_unassigned();
        int n;
        do_reset(4'b0011);
        lane_eidle[3] = 1'b0;
        lane_eidle[2] = 1'b0;
        wait_state(2'd1, QC + 10, n);
        chk(n == QC, "R4 unassigned non-idle ignored", n, QC);
        detect(4'b1100);
        chk(state_o == 2'd0 && det_lanes == '0, "R4 unassigned detect ignored", det_lanes, 0);
        lane_eidle = '1;
    endtask

    task automatic t_fail_retry();
        int n;
        do_reset(4'b0001);
        reach_active();
        detect(4'b0000);
        chk(state_o == 2'd0 && det_lanes == '0, "R5 fail returns quiet", state_o, 0);
        lane_eidle[0] = 1'b0;
        wait_state(2'd1, QC + 10, n);
        chk(n == QC, "R5 full wait after failed detect", n, QC);
        lane_eidle = '1;
        detect(4'b0000);
        wait_state(2'd1, QC + 10, n);
        chk(n == QC, "R11 timer restarts each quiet entry", n, QC);
    endtask

    task automatic t_success();
        do_reset(4'b0111);
        reach_active();
        detect(4'b1101);
        chk(state_o == 2'd2, "R6 enter polling", state_o, 2);
        chk(det_lanes == 4'b0101, "R6 detected lanes", det_lanes, 5);
    endtask

    task automatic t_override();
        int n;
        do_reset(4'b0100);
        ovrd_ctrl = 8'b0010_0000;
        reach_active();
        detect(4'b0000);
        chk(state_o == 2'd2 && det_lanes == 4'b0100, "R7 forced success", det_lanes, 4);
        wait_state(2'd0, PC + 10, n);
        chk(n == PC, "R9 polling length", n, PC);
        chk(poll_timeout == 1'b1 && det_lanes == '0, "R9 timeout pulse", poll_timeout, 1);
        @(negedge clk);
        chk(poll_timeout == 1'b0, "R9 pulse one cycle", poll_timeout, 0);
        for (int v = 0; v < 4; v++) begin
            if (v == 2) continue;
            do_reset(4'b0100);
            ovrd_ctrl = 8'(v << 4);
            reach_active();
            detect(4'b0000);
            chk(state_o == 2'd0, "R7 non-force code no effect", state_o, 0);
        end
    endtask

    task automatic t_multi();
        do_reset(4'b0011);
        ovrd_ctrl = 8'b0000_1010;
        reach_active();
        detect(4'b0000);
        chk(state_o == 2'd0 && det_lanes == '0, "R8 override ignored multi-lane", state_o, 0);
    endtask

    task automatic t_linked();
        do_reset(4'b0001);
        reach_active();
        detect(4'b0001);
        repeat (3) @(negedge clk);
        ts_done = 1'b1;
        @(negedge clk);
        ts_done = 1'b0;
        chk(state_o == 2'd3, "R10 linked", state_o, 3);
        repeat (PC + 5) @(negedge clk);
        chk(state_o == 2'd3 && !poll_timeout, "R10 linked holds", state_o, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; lane_assign = '0; lane_eidle = '1; ovrd_ctrl = '0;
        rx_det_valid = 1'b0; rx_det_result = '0; ts_done = 1'b0;
        t_reset();
        t_full_wait();
        t_early_exit();
        t_unassigned();
        t_fail_retry();
        t_success();
        t_override();
        t_multi();
        t_linked();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule